// File: doc/BRIEF.md
# Serial EEPROM Page Write Controller

This block is the storage side of a small serial EEPROM. A serial front end, which is not part of this block, decodes commands from the bus and hands them over as single-cycle requests while the device is selected. Those requests are: set or clear the write-enable latch, start a write at an address, deliver a data byte, write the protection field of the status register, and read one array byte. The array holds `DEPTH` bytes (256 by default, 512 as an option) in on-chip registers that reset to the erased value 0xFF.

Write data goes into a 16-byte page buffer. A per-byte mask records which locations were actually received. The internal write starts only when the select line returns high. At that point the block checks the write-protect pin, the latch and the protected region. If all three allow the write, it enters a self-timed programming period of `WR_CYCLES` clocks. During that period the status register shows busy, and at the end the masked bytes land in the array.

The control state machine has four states. `ST_IDLE` waits for a request. `ST_COLLECT` gathers page bytes. `ST_SRHOLD` holds a pending protection-field value. `ST_PROGRAM` is the timed write.

The transitions are:
- IDLE to COLLECT on a write start with the latch set.
- IDLE to SRHOLD on a status write with the latch set.
- COLLECT to PROGRAM on deselect, if bytes were received, the pin is high and the page is unprotected.
- COLLECT to IDLE on deselect otherwise.
- SRHOLD to PROGRAM on deselect with the pin high.
- SRHOLD to IDLE on deselect with the pin low.
- PROGRAM to IDLE when the timer expires.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset the status byte is 0x00 and every array location reads 0xFF.
- R2: `wren_cmd` sets the write-enable latch (status bit 1) and `wrdi_cmd` clears it. A write or status-write request made while the latch is clear is ignored: busy stays low and nothing changes.
- R3: Received bytes go to successive addresses whose low four bits increment and wrap within the 16-byte page. The upper address bits stay fixed, so a 17th byte overwrites the location of the first.
- R4: Only locations that received a byte are changed by a write; the rest of the page keeps its contents.
- R5: Nothing is committed while select is still low; the array shows the old contents until the write cycle that follows deselect.
- R6: A committed write holds busy (status bit 0) high for exactly `WR_CYCLES` clocks, starting with the clock after select rises. When busy falls, the latch is clear.
- R7: While busy, array reads (no `rd_vld`), latch commands, write and status-write requests are all ignored; the status byte remains readable.
- R8: If `wp_n` is low when select rises, neither the array nor the protection field changes and no write cycle starts.
- R9: The protection field (status bits 3:2) selects the protected region: 00 none, 01 the upper quarter, 10 the upper half, 11 the whole array. A write to a protected page is discarded without a write cycle.
- R10: A status write loads `wrsr_data[3:2]` into the protection field at the end of its own self-timed cycle and clears the latch. Status bits 7:4 always read zero.
- R11: A read request returns the addressed byte on `rd_data` with `rd_vld` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Device select, active low; its rising edge starts the internal write |
| wp_n | input | 1 | Hardware write protect, active low |
| wren_cmd | input | 1 | Set write-enable latch |
| wrdi_cmd | input | 1 | Clear write-enable latch |
| wr_start | input | 1 | Begin a page write at `wr_addr` |
| wr_addr | input | AW | Start address of the write |
| wr_byte_vld | input | 1 | Data byte strobe |
| wr_byte | input | 8 | Data byte |
| wrsr_req | input | 1 | Status register write request |
| wrsr_data | input | 8 | Status write value (bits 3:2 used) |
| rd_req | input | 1 | Array read request |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data |
| rd_vld | output | 1 | Read data valid |
| status | output | 8 | Status byte: bit0 busy, bit1 latch, bits3:2 protection |

## Verification
The bench aims at the page wrap: a design that carries into the upper address bits would spill the 17th and 18th bytes into the next page instead of overwriting the first two. It writes partial pages and reads the neighbouring locations, which catches a design that commits the whole buffer. It counts busy cycles exactly, which exposes an off-by-one timer. It makes requests during busy and applies protection at each region boundary, so a controller that commits early, ignores the pin or decodes the protection code wrongly shows corrupted reads or a spurious busy.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_SRHOLD,
        ST_PROGRAM
    } ctl_state_t;

    localparam int ST_BUSY_BIT = 0;
    localparam int ST_WEL_BIT  = 1;
    localparam int ST_BP_LSB   = 2;

    // top2 = two most significant address bits of the page
    function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
        unique case (bp)
            2'b00:   prot_hit = 1'b0;
            2'b01:   prot_hit = (top2 == 2'b11);
            2'b10:   prot_hit = top2[1];
            default: prot_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE = 16,
    localparam int OW = $clog2(PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OW-1:0]     start_off,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic [PAGE*8-1:0] data,
    output logic [PAGE-1:0]   mask
);
    logic [OW-1:0] off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off  <= '0;
            mask <= '0;
            data <= '0;
        end else if (start) begin
            off  <= start_off;
            mask <= '0;
        end else if (byte_vld) begin
            data[off*8 +: 8] <= byte_in;
            mask[off]        <= 1'b1;
            off              <= off + 1'b1;   // wraps inside the page
        end
    end
endmodule

// File: rtl/write_timer.sv
module write_timer #(
    parameter int WR_CYCLES = 200,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(WR_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/mem_array.sv
module mem_array #(
    parameter int DEPTH = 256,
    parameter int PAGE  = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int OW = $clog2(PAGE),
    localparam int PW = AW - OW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PW-1:0]     page_idx,
    input  logic [PAGE*8-1:0] page_data,
    input  logic [PAGE-1:0]   page_mask,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_vld
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            for (int j = 0; j < PAGE; j++)
                if (page_mask[j]) mem[{page_idx, OW'(j)}] <= page_data[j*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
    import eeprom_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int WR_CYCLES = 200,
    localparam int PAGE = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = $clog2(PAGE),
    localparam int PW   = AW - OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wp_n,
    input  logic          wren_cmd,
    input  logic          wrdi_cmd,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_byte_vld,
    input  logic [7:0]    wr_byte,
    input  logic          wrsr_req,
    input  logic [7:0]    wrsr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          rd_vld,
    output logic [7:0]    status
);
    ctl_state_t state, nxt;

    logic              sel_q;
    logic              sel_rise;
    logic              act;
    logic              wel;
    logic [1:0]        bp;
    logic [1:0]        bp_pend;
    logic              is_sr;
    logic [PW-1:0]     page_idx;
    logic [PAGE*8-1:0] buf_data;
    logic [PAGE-1:0]   buf_mask;
    logic              tmr_start;
    logic              tmr_done;
    logic              page_prot;
    logic              busy;

    assign act       = ~sel_n;
    assign sel_rise  = sel_n & ~sel_q;
    assign page_prot = prot_hit(bp, page_idx[PW-1 -: 2]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (act && wel && wr_start)      nxt = ST_COLLECT;
                else if (act && wel && wrsr_req) nxt = ST_SRHOLD;
            end
            ST_COLLECT: begin
                if (sel_rise)
                    nxt = (|buf_mask && wp_n && !page_prot) ? ST_PROGRAM : ST_IDLE;
            end
            ST_SRHOLD: begin
                if (sel_rise) nxt = wp_n ? ST_PROGRAM : ST_IDLE;
            end
            ST_PROGRAM: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state == ST_PROGRAM);
        tmr_start = (state != ST_PROGRAM) && (nxt == ST_PROGRAM);
        status    = '0;
        status[ST_BUSY_BIT]            = busy;
        status[ST_WEL_BIT]             = wel;
        status[ST_BP_LSB +: 2]         = bp;
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b1;
            wel      <= 1'b0;
            bp       <= 2'b00;
            bp_pend  <= 2'b00;
            is_sr    <= 1'b0;
            page_idx <= '0;
        end else begin
            sel_q <= sel_n;
            if (state == ST_PROGRAM) begin
                if (tmr_done) begin
                    wel <= 1'b0;
                    if (is_sr) bp <= bp_pend;
                end
            end else if (act) begin
                if (wren_cmd)      wel <= 1'b1;
                else if (wrdi_cmd) wel <= 1'b0;
            end
            if (state == ST_IDLE && nxt == ST_COLLECT) begin
                is_sr    <= 1'b0;
                page_idx <= wr_addr[AW-1:OW];
            end
            if (state == ST_IDLE && nxt == ST_SRHOLD) begin
                is_sr   <= 1'b1;
                bp_pend <= wrsr_data[3:2];
            end
        end
    end

    page_buffer #(.PAGE(PAGE)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (state == ST_IDLE && nxt == ST_COLLECT),
        .start_off (wr_addr[OW-1:0]),
        .byte_vld  (state == ST_COLLECT && act && wr_byte_vld),
        .byte_in   (wr_byte),
        .data      (buf_data),
        .mask      (buf_mask)
    );

    write_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    mem_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (busy && tmr_done && !is_sr),
        .page_idx  (page_idx),
        .page_data (buf_data),
        .page_mask (buf_mask),
        .rd_en     (act && rd_req && !busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_vld    (rd_vld)
    );
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n,
    input logic       wp_n,
    input logic       rd_req,
    input logic       rd_vld,
    input logic [7:0] status
);
    // R6: busy only starts the cycle after select rose
    a_r6_busy_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> ($past(sel_n) && !$past(sel_n, 2)));

    // R6: latch is clear when a write cycle ends
    a_r6_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    // R2: a write cycle needs the latch set
    a_r2_wel_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(status[1]));

    // R7: no read data while busy
    a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> !rd_vld);

    // R7: protection field frozen until the cycle ends
    a_r7_bp_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> ($stable(status[3:2]) || !status[0]));

    // R8: no write cycle with the pin low
    a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(wp_n));

    // R11: read data only after a selected request
    a_r11_rd_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_req && !sel_n));

    // R10: reserved status bits
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'h0);
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .wp_n   (wp_n),
    .rd_req (rd_req),
    .rd_vld (rd_vld),
    .status (status)
);

// File: tb/eeprom_page_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_page_ctrl_test;
    localparam int DEPTH = 256;
    localparam int WRC   = 200;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1, wp_n = 1'b1;
    logic          wren_cmd = 1'b0, wrdi_cmd = 1'b0;
    logic          wr_start = 1'b0, wr_byte_vld = 1'b0, wrsr_req = 1'b0, rd_req = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_byte = '0, wrsr_data = '0;
    logic [7:0]    rd_data, status;
    logic          rd_vld;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    eeprom_page_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WRC)) uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cmd_wren();
        @(negedge clk) sel_n = 1'b0; wren_cmd = 1'b1;
        @(negedge clk) wren_cmd = 1'b0; sel_n = 1'b1;
    endtask

    task automatic cmd_wrdi();
        @(negedge clk) sel_n = 1'b0; wrdi_cmd = 1'b1;
        @(negedge clk) wrdi_cmd = 1'b0; sel_n = 1'b1;
    endtask

    // leaves select low
    task automatic send_bytes(input logic [7:0] a, input int n, input logic [7:0] base);
        @(negedge clk) sel_n = 1'b0;
        @(negedge clk) wr_start = 1'b1; wr_addr = a;
        @(negedge clk) wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_byte_vld = 1'b1; wr_byte = base + 8'(i);
            @(negedge clk);
        end
        wr_byte_vld = 1'b0;
    endtask

    task automatic send_sr(input logic [7:0] v);
        @(negedge clk) sel_n = 1'b0; wrsr_req = 1'b1; wrsr_data = v;
        @(negedge clk) wrsr_req = 1'b0;
    endtask

    // raise select and count busy cycles
    task automatic deselect_count(output int n);
        n = 0;
        @(negedge clk) sel_n = 1'b1;
        @(negedge clk);
        while (status[0] && n < 10*WRC) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] d, output logic v);
        @(negedge clk) sel_n = 1'b0; rd_req = 1'b1; rd_addr = a;
        @(negedge clk) rd_req = 1'b0; d = rd_data; v = rd_vld; sel_n = 1'b1;
    endtask

    task automatic expect_byte(input logic [7:0] a, input logic [7:0] e, input string req);
        logic [7:0] d; logic v;
        read_byte(a, d, v);
        check(v && d == e, req, {v, d}, {1'b1, e});
    endtask

    task automatic t_reset();
        check(status == 8'h00, "R1 status", status, 0);
        expect_byte(8'h00, 8'hFF, "R1/R11 addr 00");
        expect_byte(8'hFF, 8'hFF, "R1/R11 addr FF");
    endtask

    task automatic t_latch();
        int n;
        send_bytes(8'h10, 2, 8'h55);
        deselect_count(n);
        check(n == 0, "R2 write with latch clear", n, 0);
        expect_byte(8'h10, 8'hFF, "R2 data unchanged");
        send_sr(8'h0C);
        deselect_count(n);
        check(n == 0 && status == 8'h00, "R2 status write with latch clear", status, 0);
        cmd_wren();
        check(status[1] == 1'b1, "R2 wren", status, 2);
        cmd_wrdi();
        check(status[1] == 1'b0, "R2 wrdi", status, 0);
    endtask

    task automatic t_partial();
        int n;
        cmd_wren();
        send_bytes(8'h23, 3, 8'hA0);
        expect_byte(8'h23, 8'hFF, "R5 no commit before deselect");
        sel_n = 1'b0;
        deselect_count(n);
        check(n == WRC, "R6 busy length", n, WRC);
        check(status[1] == 1'b0, "R6 latch cleared", status, 0);
        expect_byte(8'h22, 8'hFF, "R4 below range");
        expect_byte(8'h23, 8'hA0, "R4 byte0");
        expect_byte(8'h24, 8'hA1, "R4 byte1");
        expect_byte(8'h25, 8'hA2, "R4 byte2");
        expect_byte(8'h26, 8'hFF, "R4 above range");
    endtask

    task automatic t_wrap();
        int n;
        cmd_wren();
        send_bytes(8'h4E, 18, 8'h80);
        deselect_count(n);
        check(n == WRC, "R3 busy length", n, WRC);
        expect_byte(8'h40, 8'h82, "R3 wrapped offset 0");
        expect_byte(8'h4D, 8'h8F, "R3 offset D");
        expect_byte(8'h4E, 8'h90, "R3 overwrite first");
        expect_byte(8'h4F, 8'h91, "R3 overwrite second");
        expect_byte(8'h50, 8'hFF, "R3 next page untouched");
    endtask

    task automatic t_busy();
        int n;
        logic [7:0] d; logic v;
        cmd_wren();
        send_bytes(8'h60, 1, 8'h11);
        @(negedge clk) sel_n = 1'b1;
        @(negedge clk);
        check(status[0] == 1'b1, "R7 status readable while busy", status, 1);
        read_byte(8'h60, d, v);
        check(v == 1'b0, "R7 read ignored while busy", v, 0);
        cmd_wrdi();
        check(status[1] == 1'b1, "R7 wrdi ignored while busy", status, 3);
        send_bytes(8'h70, 1, 8'h22);
        deselect_count(n);
        check(status == 8'h00, "R7 idle after cycle", status, 0);
        expect_byte(8'h70, 8'hFF, "R7 write ignored while busy");
        expect_byte(8'h60, 8'h11, "R7 first write landed");
    endtask

    task automatic t_wp();
        int n;
        cmd_wren();
        wp_n = 1'b0;
        send_bytes(8'h30, 2, 8'h33);
        deselect_count(n);
        check(n == 0, "R8 no cycle with pin low", n, 0);
        expect_byte(8'h30, 8'hFF, "R8 array unchanged");
        send_sr(8'h0C);
        deselect_count(n);
        check(n == 0 && status == 8'h02, "R8 status unchanged", status, 2);
        wp_n = 1'b1;
        cmd_wrdi();
    endtask

    task automatic set_bp(input logic [1:0] code);
        int n;
        cmd_wren();
        send_sr({4'h0, code, 2'b00});
        deselect_count(n);
        check(n == WRC && status == {4'h0, code, 2'b00}, "R10 status write", status, {code, 2'b00});
    endtask

    task automatic try_write(input logic [7:0] a, input bit allowed, input logic [7:0] v);
        int n;
        cmd_wren();
        send_bytes(a, 1, v);
        deselect_count(n);
        check(n == (allowed ? WRC : 0), "R9 cycle count", n, allowed ? WRC : 0);
        expect_byte(a, allowed ? v : 8'hFF, "R9 protected region");
        if (!allowed) cmd_wrdi();
    endtask

    task automatic t_protect();
        set_bp(2'b01);
        try_write(8'hC0, 1'b0, 8'h01);
        try_write(8'hB0, 1'b1, 8'h02);
        set_bp(2'b10);
        try_write(8'h80, 1'b0, 8'h03);
        try_write(8'h7F, 1'b1, 8'h04);
        set_bp(2'b11);
        try_write(8'h00, 1'b0, 8'h05);
        set_bp(2'b00);
        try_write(8'hF0, 1'b1, 8'h06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_partial();
        t_wrap();
        t_busy();
        t_wp();
        t_protect();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule